// File: doc/BRIEF.md
# UART Data Register Access Interface

This block is the processor-facing side of a UART's data path. A single bus address holds two separate registers: a read returns the word at the head of the receive path, and a write loads the transmit path. The ninth data bit travels through a control register. For transmit, the ninth bit is staged in a holding latch and only committed when the data register is written. For receive, the head word's ninth bit and its extra per-word flags can be read from side registers, and those reads have no side effects.

A data-register read pops the receive path and clears the receive-ready flag. It only clears the flag when the receive level is below the programmed watermark. The block also combines the framing-error and parity-error flags with their enable bits into one level-sensitive interrupt request. Serial shifting, baud timing and FIFO storage sit outside the block. They connect through stub ports: `rx_head`, `rx_ext`, `rx_level`, `tx_word` and the two strobes.

A small access sequencer drives the two strobes. It has three states:
- `ST_IDLE`: no strobe is active.
- `ST_PUSH`: `tx_push` is high.
- `ST_POP`: `rx_pop` is high.

From any state, the sequencer moves on the next clock edge as follows:
- A data-register write moves it to `ST_PUSH`.
- A data-register read moves it to `ST_POP`.
- Any other cycle moves it to `ST_IDLE`.

When `bus_wr` and `bus_rd` are both high, the access is treated as a write.

Register map:

| Address | Register | Read | Write |
|---|---|---|---|
| 0 | Data | Receive byte | Transmit byte |
| 1 | Control | Bit 7 = head ninth bit, bit 6 = staged transmit ninth bit, bit 1 = framing-error enable, bit 0 = parity-error enable | Bit 6, bit 1 and bit 0 are written; bit 7 is read-only |
| 2 | Extended flags | Head-word flags, zero-extended | — |
| 3 | Unmapped | Returns 0 | Ignored |

Top module: `uart_dreg_if`

## Requirements
- R1: A write to address 0 loads `tx_word` with {staged bit, written byte} and raises `tx_push` for exactly the one cycle after the write edge.
- R2: A control write (address 1) stores bit 6 in the holding latch without pushing. `tx_word` is unchanged until the next data write.
- R3: The staged ninth bit persists across data writes. Two data writes with no control write in between both carry the same bit 8.
- R4: A read of address 0 returns `rx_head[7:0]` unmasked, including bit 7 when that bit is a parity bit. `bus_rdata` is valid the cycle after the read edge, and `rx_pop` is high for that one cycle.
- R5: A control read returns bit 7 = `rx_head[8]`, bit 6 = staged bit, bit 1 = framing-error enable and bit 0 = parity-error enable, with no pop.
- R6: A read of address 2 returns `rx_ext` zero-extended, with no pop.
- R7: `rx_ready` is set on any edge where `rx_level >= rx_water`. A data read clears it only when the level is below the watermark at that edge; setting wins. Otherwise it holds.
- R8: `err_irq` equals (`rx_fe` AND framing enable) OR (`rx_pf` AND parity enable), as a continuous level.
- R9: After reset, the strobes, `rx_ready`, the enables, the staged bit, `tx_word` and `bus_rdata` are all 0.
- R10: Address 3 reads 0 and ignores writes: there is no push and no control change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_word | output | 9 | Word for the transmit path |
| tx_push | output | 1 | One-cycle transmit push |
| rx_head | input | 9 | Word at the head of the receive path |
| rx_ext | input | 2 | Extra flags of the head word |
| rx_level | input | 5 | Receive buffer fill level |
| rx_water | input | 5 | Receive watermark |
| rx_pop | output | 1 | One-cycle receive pop |
| rx_fe | input | 1 | Framing-error flag |
| rx_pf | input | 1 | Parity-error flag |
| rx_ready | output | 1 | Receive-data-ready flag |
| err_irq | output | 1 | Error interrupt request |

## Verification
A data-register read can land on the same edge where the receive level is at or above the watermark. In that case the flag's set path and its read-clear path act together. The bench provokes this by holding `rx_level` above `rx_water` while it reads address 0. It judges the outcome by checking that `rx_ready` stays high even though the pop strobe still fires. It then lowers the level and reads again to confirm that the clear does take effect when no set is present.

// File: rtl/uart_dreg_pkg.sv
package uart_dreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2
    } acc_state_e;

    localparam logic [1:0] ADR_DATA  = 2'd0;
    localparam logic [1:0] ADR_CTRL  = 2'd1;
    localparam logic [1:0] ADR_EXT   = 2'd2;
    localparam logic [1:0] ADR_SPARE = 2'd3;

    localparam int CB_PE_EN = 0;
    localparam int CB_FE_EN = 1;
    localparam int CB_T8    = 6;
    localparam int CB_R8    = 7;

endpackage

// File: rtl/dreg_access_fsm.sv
module dreg_access_fsm
    import uart_dreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_data_hit,
    input  logic rd_data_hit,
    output logic tx_push,
    output logic rx_pop
);

    acc_state_e state_q;
    acc_state_e state_d;

    always_comb begin
        unique case (1'b1)
            wr_data_hit: state_d = ST_PUSH;
            rd_data_hit: state_d = ST_POP;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        tx_push = 1'b0;
        rx_pop  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin end
            ST_PUSH: tx_push = 1'b1;
            ST_POP:  rx_pop  = 1'b1;
            default: begin end
        endcase
    end

endmodule

// File: rtl/dreg_ctrl_file.sv
module dreg_ctrl_file
    import uart_dreg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              t8_hold,
    output logic              fe_en,
    output logic              pe_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t8_hold <= 1'b0;
            fe_en   <= 1'b0;
            pe_en   <= 1'b0;
        end else if (ctrl_wr) begin
            t8_hold <= wdata[CB_T8];
            fe_en   <= wdata[CB_FE_EN];
            pe_en   <= wdata[CB_PE_EN];
        end
    end

endmodule

// File: rtl/dreg_tx_stage.sv
module dreg_tx_stage #(
    parameter int DATA_W = 8,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              t8_hold,
    output logic [WORD_W-1:0] tx_word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_word <= '0;
        end else if (wr_data_hit) begin
            tx_word <= {t8_hold, wdata};
        end
    end

endmodule

// File: rtl/dreg_rx_side.sv
module dreg_rx_side
    import uart_dreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int EXT_W  = 2,
    parameter int LVL_W  = 5,
    parameter int ADDR_W = 2,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_any,
    input  logic              rd_data_hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] rx_head,
    input  logic [EXT_W-1:0]  rx_ext,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  rx_water,
    input  logic              t8_hold,
    input  logic              fe_en,
    input  logic              pe_en,
    input  logic              rx_fe,
    input  logic              rx_pf,
    output logic [DATA_W-1:0] rdata,
    output logic              rx_ready,
    output logic              err_irq
);

    logic [DATA_W-1:0] rd_mux;
    logic              at_water;

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            ADR_DATA:  rd_mux = rx_head[DATA_W-1:0];
            ADR_CTRL: begin
                rd_mux[CB_R8]    = rx_head[DATA_W];
                rd_mux[CB_T8]    = t8_hold;
                rd_mux[CB_FE_EN] = fe_en;
                rd_mux[CB_PE_EN] = pe_en;
            end
            ADR_EXT:   rd_mux[EXT_W-1:0] = rx_ext;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_any) begin
            rdata <= rd_mux;
        end
    end

    assign at_water = (rx_level >= rx_water);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_ready <= 1'b0;
        end else if (at_water) begin
            rx_ready <= 1'b1;
        end else if (rd_data_hit) begin
            rx_ready <= 1'b0;
        end
    end

    assign err_irq = (rx_fe & fe_en) | (rx_pf & pe_en);

endmodule

// File: rtl/uart_dreg_if.sv
module uart_dreg_if
    import uart_dreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int EXT_W  = 2,
    parameter int LVL_W  = 5,
    parameter int ADDR_W = 2,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_push,
    input  logic [WORD_W-1:0] rx_head,
    input  logic [EXT_W-1:0]  rx_ext,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  rx_water,
    output logic              rx_pop,
    input  logic              rx_fe,
    input  logic              rx_pf,
    output logic              rx_ready,
    output logic              err_irq
);

    logic wr_any, rd_any;
    logic wr_data_hit, rd_data_hit, ctrl_wr;
    logic t8_hold, fe_en, pe_en;

    assign wr_any      = bus_sel & bus_wr;
    assign rd_any      = bus_sel & bus_rd & ~bus_wr;
    assign wr_data_hit = wr_any & (bus_addr == ADR_DATA);
    assign rd_data_hit = rd_any & (bus_addr == ADR_DATA);
    assign ctrl_wr     = wr_any & (bus_addr == ADR_CTRL);

    dreg_access_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_data_hit (wr_data_hit),
        .rd_data_hit (rd_data_hit),
        .tx_push     (tx_push),
        .rx_pop      (rx_pop)
    );

    dreg_ctrl_file #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .t8_hold (t8_hold),
        .fe_en   (fe_en),
        .pe_en   (pe_en)
    );

    dreg_tx_stage #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_data_hit (wr_data_hit),
        .wdata       (bus_wdata),
        .t8_hold     (t8_hold),
        .tx_word     (tx_word)
    );

    dreg_rx_side #(
        .DATA_W (DATA_W),
        .EXT_W  (EXT_W),
        .LVL_W  (LVL_W),
        .ADDR_W (ADDR_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_any      (rd_any),
        .rd_data_hit (rd_data_hit),
        .addr        (bus_addr),
        .rx_head     (rx_head),
        .rx_ext      (rx_ext),
        .rx_level    (rx_level),
        .rx_water    (rx_water),
        .t8_hold     (t8_hold),
        .fe_en       (fe_en),
        .pe_en       (pe_en),
        .rx_fe       (rx_fe),
        .rx_pf       (rx_pf),
        .rdata       (bus_rdata),
        .rx_ready    (rx_ready),
        .err_irq     (err_irq)
    );

endmodule

// File: rtl/uart_dreg_if_chk.sv
module uart_dreg_if_chk #(
    parameter int DATA_W = 8,
    parameter int EXT_W  = 2,
    parameter int LVL_W  = 5,
    parameter int ADDR_W = 2,
    localparam int WORD_W = DATA_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [WORD_W-1:0] tx_word,
    input logic              tx_push,
    input logic [WORD_W-1:0] rx_head,
    input logic [LVL_W-1:0]  rx_level,
    input logic [LVL_W-1:0]  rx_water,
    input logic              rx_pop,
    input logic              rx_fe,
    input logic              rx_pf,
    input logic              rx_ready,
    input logic              err_irq,
    input logic              t8_hold,
    input logic              fe_en,
    input logic              pe_en
);

    logic wr_d, rd_d, rd_side;
    assign wr_d    = bus_sel && bus_wr && (bus_addr == '0);
    assign rd_d    = bus_sel && bus_rd && !bus_wr && (bus_addr == '0);
    assign rd_side = bus_sel && bus_rd && !bus_wr && (bus_addr != '0);

    // R1
    push_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_d |=> (tx_push && tx_word[DATA_W-1:0] == $past(bus_wdata)));

    // R1
    push_only_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_d |=> !tx_push);

    // R3
    push_bit8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_d |=> (tx_word[DATA_W] == $past(t8_hold)));

    // R4
    pop_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_d |=> (rx_pop && bus_rdata == $past(rx_head[DATA_W-1:0])));

    // R6
    side_read_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_side |=> !rx_pop);

    // R7
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= rx_water) |=> rx_ready);

    // R7
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_d) |=> rx_ready);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == ((rx_fe && fe_en) || (rx_pf && pe_en)));

endmodule

bind uart_dreg_if uart_dreg_if_chk #(
    .DATA_W (DATA_W),
    .EXT_W  (EXT_W),
    .LVL_W  (LVL_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_word   (tx_word),
    .tx_push   (tx_push),
    .rx_head   (rx_head),
    .rx_level  (rx_level),
    .rx_water  (rx_water),
    .rx_pop    (rx_pop),
    .rx_fe     (rx_fe),
    .rx_pf     (rx_pf),
    .rx_ready  (rx_ready),
    .err_irq   (err_irq),
    .t8_hold   (t8_hold),
    .fe_en     (fe_en),
    .pe_en     (pe_en)
);

// File: tb/uart_dreg_if_test.sv
`timescale 1ns/1ps
module uart_dreg_if_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [8:0] tx_word;
    logic       tx_push;
    logic [8:0] rx_head = 9'd0;
    logic [1:0] rx_ext = 2'd0;
    logic [4:0] rx_level = 5'd0;
    logic [4:0] rx_water = 5'd1;
    logic       rx_pop;
    logic       rx_fe = 1'b0, rx_pf = 1'b0;
    logic       rx_ready, err_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_dreg_if uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_word(tx_word), .tx_push(tx_push),
        .rx_head(rx_head), .rx_ext(rx_ext), .rx_level(rx_level),
        .rx_water(rx_water), .rx_pop(rx_pop), .rx_fe(rx_fe), .rx_pf(rx_pf),
        .rx_ready(rx_ready), .err_irq(err_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        rx_fe = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 tx_push", 16'(tx_push), 16'd0);
        check("R9 rx_pop", 16'(rx_pop), 16'd0);
        check("R9 rdata", 16'(bus_rdata), 16'd0);
        check("R9 tx_word", 16'(tx_word), 16'd0);
        check("R9 rx_ready", 16'(rx_ready), 16'd0);
        check("R9 irq gated", 16'(err_irq), 16'd0);
        rx_fe = 1'b0;
    endtask

    task automatic t_tx;
        bus_write(2'd1, 8'h40);
        check("R2 no push on ctrl write", 16'(tx_push), 16'd0);
        check("R2 tx_word unchanged", 16'(tx_word), 16'h000);
        bus_write(2'd0, 8'hA5);
        check("R1 push strobe", 16'(tx_push), 16'd1);
        check("R1 tx_word", 16'(tx_word), 16'h1A5);
        @(negedge clk);
        check("R1 single-cycle push", 16'(tx_push), 16'd0);
        bus_write(2'd0, 8'h3C);
        check("R3 bit8 reused", 16'(tx_word), 16'h13C);
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'hFF);
        check("R3 bit8 restaged", 16'(tx_word), 16'h0FF);
    endtask

    task automatic t_rx;
        rx_head = 9'h1C3;
        rx_ext  = 2'b10;
        bus_read(2'd1);
        check("R5 ctrl read", 16'(bus_rdata), 16'h80);
        check("R5 no pop", 16'(rx_pop), 16'd0);
        bus_read(2'd2);
        check("R6 ext read", 16'(bus_rdata), 16'h02);
        check("R6 no pop", 16'(rx_pop), 16'd0);
        bus_read(2'd0);
        check("R4 data with parity bit", 16'(bus_rdata), 16'hC3);
        check("R4 pop strobe", 16'(rx_pop), 16'd1);
        @(negedge clk);
        check("R4 single-cycle pop", 16'(rx_pop), 16'd0);
    endtask

    task automatic t_irq;
        bus_write(2'd1, 8'h02);
        rx_fe = 1'b1; #1;
        check("R8 fe enabled", 16'(err_irq), 16'd1);
        rx_fe = 1'b0; #1;
        check("R8 fe cleared", 16'(err_irq), 16'd0);
        rx_pf = 1'b1; #1;
        check("R8 pf disabled", 16'(err_irq), 16'd0);
        bus_write(2'd1, 8'h01);
        check("R8 pf enabled", 16'(err_irq), 16'd1);
        rx_pf = 1'b0; #1;
        check("R8 pf cleared", 16'(err_irq), 16'd0);
    endtask

    task automatic t_ready;
        rx_water = 5'd2;
        rx_level = 5'd3;
        @(negedge clk);
        check("R7 set at watermark", 16'(rx_ready), 16'd1);
        bus_read(2'd0);
        check("R7 set wins over read clear", 16'(rx_ready), 16'd1);
        check("R7 pop during collision", 16'(rx_pop), 16'd1);
        rx_level = 5'd1;
        @(negedge clk);
        @(negedge clk);
        check("R7 holds without read", 16'(rx_ready), 16'd1);
        bus_read(2'd0);
        check("R7 read clears below watermark", 16'(rx_ready), 16'd0);
    endtask

    task automatic t_spare;
        bus_write(2'd1, 8'h43);
        bus_write(2'd3, 8'h00);
        check("R10 no push on spare write", 16'(tx_push), 16'd0);
        bus_read(2'd3);
        check("R10 spare reads zero", 16'(bus_rdata), 16'd0);
        check("R10 no pop on spare read", 16'(rx_pop), 16'd0);
        rx_head = 9'h000;
        bus_read(2'd1);
        check("R10 ctrl untouched", 16'(bus_rdata), 16'h43);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_tx();
                t_rx();
                t_irq();
                t_ready();
                t_spare();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule